// File: doc/BRIEF.md
# DMA Request Routing Channel

This block is one channel of a DMA request router. It picks one line out of a vector of peripheral DMA request lines and drives it to a single DMA controller channel. A 7-bit line number chooses the line. Line number 0 means that no line is chosen.

The channel works in two modes. In direct mode the chosen line goes straight to the output. In gated mode the chosen line reaches the output only after a qualified edge on a selected synchronization input. After that edge, the line stays connected for a programmed number of served requests and then disconnects.

A reloading down-counter tracks the served requests. It can raise a one-cycle event pulse each time it wraps. It also decides when a further synchronization edge counts as an overrun. An overrun sets a sticky flag, and that flag can drive an interrupt.

Top module: `dma_route_channel`

## Requirements
- R1: When `cfg_req_id` is 0, `req_out` stays low whatever the request lines do.
- R2: When `cfg_sync_en` is 0, `req_out` equals `req_in[cfg_req_id]` in the same cycle, for every non-zero line number.
- R3: `cfg_sync_pol` selects the qualifying sync edge: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 either. An edge is detected in the clock cycle after the selected sync input changes level.
- R4: In gated mode, a sync edge that arrives while the chosen line is low is dropped. A later request then stays blocked until another sync edge arrives.
- R5: In gated mode, a sync edge that arrives while the chosen line is high connects the line. The connection lasts for exactly `cfg_count`+1 served requests, after which `req_out` is low again.
- R6: A request counts as served when the chosen line falls while `req_out` was high in the previous cycle. Activity on other lines has no effect on the counter. The counter is reloaded from `cfg_count` whenever `cfg_sync_en` and `cfg_event_en` are both 0.
- R7: With `cfg_event_en` set, `event_pulse` is high for exactly one cycle, in the cycle after every (`cfg_count`+1)-th served request. This applies in both modes, so a count of 0 gives a pulse after each served request.
- R8: In gated mode, a sync edge that arrives while the line is connected sets `ovr_flag`. The flag stays set until a cycle with `ovr_clear` high. If a set and a clear fall in the same cycle, the flag ends up set.
- R9: `ovr_irq` is high exactly when `ovr_flag` and `cfg_ovr_ie` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NUM_REQ | Peripheral request lines |
| sync_in | input | NUM_SYNC | Synchronization inputs |
| cfg_req_id | input | REQ_ID_W | Chosen request line, 0 = none |
| cfg_sync_id | input | SYNC_ID_W | Chosen sync input |
| cfg_count | input | CNT_W | Served requests per window, minus one |
| cfg_sync_pol | input | 2 | Qualifying sync edge |
| cfg_sync_en | input | 1 | Gated mode enable |
| cfg_event_en | input | 1 | Event pulse enable |
| cfg_ovr_ie | input | 1 | Overrun interrupt enable |
| ovr_clear | input | 1 | Clears the overrun flag |
| req_out | output | 1 | Request to the DMA channel |
| event_pulse | output | 1 | One-cycle counter wrap event |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
Two things can land in the same clock cycle: a new overrun and a flag clear. To provoke this, the bench keeps a window open in gated mode. It then raises a fresh sync edge in the same cycle that it drives `ovr_clear`. It judges the result by requiring `ovr_flag` to be set after that edge.

A second pairing is the final served request together with the counter reload. The bench sweeps count values 0 to 5. For each count it checks that `req_out` is high on each of the count+1 requests, that the event pulse appears only after the last one, and that the next request is blocked.

// File: rtl/drc_pkg.sv
package drc_pkg;
   typedef enum logic [1:0] {
      POL_NONE = 2'b00,
      POL_RISE = 2'b01,
      POL_FALL = 2'b10,
      POL_BOTH = 2'b11
   } sync_pol_e;
endpackage

// File: rtl/drc_line_pick.sv
module drc_line_pick #(
   parameter int NUM         = 128,
   parameter int ID_W        = 7,
   parameter bit ZERO_IS_OFF = 1'b1
) (
   input  logic [NUM-1:0]  lines,
   input  logic [ID_W-1:0] id,
   output logic            picked
);
   localparam logic [ID_W:0] LIMIT = NUM[ID_W:0];

   logic in_range;

   generate
      if (NUM == (1 << ID_W)) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_partial
         assign in_range = ({1'b0, id} < LIMIT);
      end

      if (ZERO_IS_OFF) begin : g_zero_off
         assign picked = (id != '0) && in_range && lines[id];
      end else begin : g_zero_on
         assign picked = in_range && lines[id];
      end
   endgenerate

   generate
      if (NUM < 2 || NUM > (1 << ID_W)) begin : g_bad_cfg
         $error("drc_line_pick: NUM does not fit ID_W");
      end
   endgenerate
endmodule

// File: rtl/drc_edge_sense.sv
module drc_edge_sense
   import drc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sig,
   input  sync_pol_e pol,
   output logic      evt
);
   logic sig_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig;
   end

   assign rise = sig & ~sig_q;
   assign fall = ~sig & sig_q;
   assign evt  = (pol[0] & rise) | (pol[1] & fall);

   // R3: an accepted event always coincides with a level change
   assert_edge_is_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (sig_q != $past(sig_q)));
endmodule

// File: rtl/drc_req_counter.sv
module drc_req_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             served,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             ev_en,
   output logic             underrun,
   output logic             event_pulse
);
   logic [CNT_W-1:0] cnt_q;
   logic             ev_q;

   assign underrun = served & ~hold & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ev_q  <= 1'b0;
      end else begin
         ev_q <= ev_en & underrun;
         if (hold)              cnt_q <= reload_val;
         else if (underrun)     cnt_q <= reload_val;
         else if (served)       cnt_q <= cnt_q - 1'b1;
      end
   end

   assign event_pulse = ev_q;

   // R7: the event lasts one cycle (serves are at least two cycles apart)
   assert_event_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      event_pulse |=> !event_pulse);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("drc_req_counter: CNT_W out of range");
      end
   endgenerate
endmodule

// File: rtl/dma_route_channel.sv
module dma_route_channel
   import drc_pkg::*;
#(
   parameter int NUM_REQ   = 128,
   parameter int NUM_SYNC  = 32,
   parameter int CNT_W     = 5,
   parameter int REQ_ID_W  = $clog2(NUM_REQ),
   parameter int SYNC_ID_W = $clog2(NUM_SYNC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_REQ-1:0]   req_in,
   input  logic [NUM_SYNC-1:0]  sync_in,
   input  logic [REQ_ID_W-1:0]  cfg_req_id,
   input  logic [SYNC_ID_W-1:0] cfg_sync_id,
   input  logic [CNT_W-1:0]     cfg_count,
   input  logic [1:0]           cfg_sync_pol,
   input  logic                 cfg_sync_en,
   input  logic                 cfg_event_en,
   input  logic                 cfg_ovr_ie,
   input  logic                 ovr_clear,
   output logic                 req_out,
   output logic                 event_pulse,
   output logic                 ovr_flag,
   output logic                 ovr_irq
);
   logic sel_req, sel_sync, sync_evt;
   logic gate_q, out_q, ovr_q;
   logic served, underrun, ovr_set;

   drc_line_pick #(.NUM(NUM_REQ), .ID_W(REQ_ID_W), .ZERO_IS_OFF(1'b1)) req_pick_i (
      .lines(req_in), .id(cfg_req_id), .picked(sel_req));

   drc_line_pick #(.NUM(NUM_SYNC), .ID_W(SYNC_ID_W), .ZERO_IS_OFF(1'b0)) sync_pick_i (
      .lines(sync_in), .id(cfg_sync_id), .picked(sel_sync));

   drc_edge_sense edge_i (
      .clk(clk), .rst_n(rst_n), .sig(sel_sync),
      .pol(sync_pol_e'(cfg_sync_pol)), .evt(sync_evt));

   assign req_out = sel_req & (~cfg_sync_en | gate_q);
   assign served  = out_q & ~sel_req;
   assign ovr_set = cfg_sync_en & gate_q & sync_evt;

   drc_req_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n),
      .hold(~cfg_sync_en & ~cfg_event_en),
      .served(served), .reload_val(cfg_count), .ev_en(cfg_event_en),
      .underrun(underrun), .event_pulse(event_pulse));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         out_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         out_q <= req_out;
         if (!cfg_sync_en)  gate_q <= 1'b0;
         else if (gate_q)   gate_q <= ~underrun;
         else               gate_q <= sync_evt & sel_req;
         ovr_q <= ovr_set | (ovr_q & ~ovr_clear);
      end
   end

   assign ovr_flag = ovr_q;
   assign ovr_irq  = ovr_q & cfg_ovr_ie;

   assert_no_line_when_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_id == '0) |-> !req_out);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ovr_clear) |=> ovr_flag);

   assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_set |=> ovr_flag);

   assert_closed_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sync_en && $stable(cfg_sync_en) && !gate_q && !sync_evt) |=> (!req_out || !$stable(cfg_sync_en)));

   generate
      if (NUM_SYNC < 2 || NUM_SYNC > (1 << SYNC_ID_W)) begin : g_bad_sync
         $error("dma_route_channel: NUM_SYNC does not fit SYNC_ID_W");
      end
   endgenerate
endmodule

// File: tb/dma_route_channel_tb_top.sv
module dma_route_channel_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] req_in = '0;
   logic [31:0]  sync_in = '0;
   logic [6:0]   cfg_req_id = '0;
   logic [4:0]   cfg_sync_id = '0;
   logic [4:0]   cfg_count = '0;
   logic [1:0]   cfg_sync_pol = 2'b00;
   logic         cfg_sync_en = 1'b0, cfg_event_en = 1'b0, cfg_ovr_ie = 1'b0, ovr_clear = 1'b0;
   logic         req_out, event_pulse, ovr_flag, ovr_irq;
   int           total = 0, bad = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;

   dma_route_channel dut_i (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .sync_in(sync_in),
      .cfg_req_id(cfg_req_id), .cfg_sync_id(cfg_sync_id), .cfg_count(cfg_count),
      .cfg_sync_pol(cfg_sync_pol), .cfg_sync_en(cfg_sync_en),
      .cfg_event_en(cfg_event_en), .cfg_ovr_ie(cfg_ovr_ie), .ovr_clear(ovr_clear),
      .req_out(req_out), .event_pulse(event_pulse), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq));

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic idle_channel();
      cfg_sync_en = 0; cfg_event_en = 0; req_in = '0; ovr_clear = 0;
      tick(); tick();
   endtask

   task automatic sync_pulse(int sid);
      sync_in[sid] = 1'b1; tick();
      sync_in[sid] = 1'b0; tick();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      chk("R1 reset req_out", req_out, 1'b0);
      chk("R7 reset event", event_pulse, 1'b0);
      chk("R8 reset flag", ovr_flag, 1'b0);
      chk("R9 reset irq", ovr_irq, 1'b0);

      // R1: id 0 selects nothing
      cfg_req_id = 0; req_in = '1; #1;
      chk("R1 id zero all lines high", req_out, 1'b0);
      tick();
      chk("R1 id zero after edge", req_out, 1'b0);
      req_in = '0;

      // R2: direct mode sweep over all line numbers
      for (int id = 1; id < 128; id++) begin
         cfg_req_id = 7'(id);
         req_in = '0; req_in[id] = 1'b1; #1;
         chk("R2 selected line high", req_out, 1'b1);
         req_in = '1; req_in[id] = 1'b0; #1;
         chk("R2 selected line low", req_out, 1'b0);
      end
      req_in = '0; tick(); tick();

      // R5/R7: gated windows for count 0..5
      for (int n = 0; n < 6; n++) begin
         int sid;
         sid = n + 3;
         cfg_req_id = 7'd5; cfg_sync_id = 5'(sid); cfg_count = 5'(n);
         cfg_sync_pol = 2'b01;
         idle_channel();
         cfg_sync_en = 1; cfg_event_en = 1; tick();
         req_in[5] = 1'b1; #1;
         chk("R5 blocked before sync", req_out, 1'b0);
         sync_pulse(sid);
         for (int k = 0; k <= n; k++) begin
            req_in[5] = 1'b1; #1;
            chk("R5 forwarded in window", req_out, 1'b1);
            tick();
            req_in[5] = 1'b0; tick();
            chk("R7 event after serve", event_pulse, (k == n));
         end
         tick();
         chk("R7 event one cycle", event_pulse, 1'b0);
         req_in[5] = 1'b1; #1;
         chk("R5 disconnected after count+1", req_out, 1'b0);
         tick();
         chk("R5 still disconnected", req_out, 1'b0);
         req_in[5] = 1'b0; tick();
      end

      // R4: sync edge with nothing pending is dropped
      cfg_req_id = 7'd20; cfg_sync_id = 5'd2; cfg_count = 5'd1; cfg_sync_pol = 2'b01;
      idle_channel();
      cfg_sync_en = 1; tick();
      sync_pulse(2);
      req_in[20] = 1'b1; #1;
      chk("R4 dropped sync keeps blocked", req_out, 1'b0);
      tick(); tick();
      chk("R4 still blocked later", req_out, 1'b0);
      sync_pulse(2);
      chk("R4 next sync connects", req_out, 1'b1);
      idle_channel();

      // R3: polarity encodings against rising and falling edges
      for (int pol = 0; pol < 4; pol++) begin
         for (int s0 = 0; s0 < 2; s0++) begin
            logic exp_open;
            exp_open = (s0 == 0) ? pol[0] : pol[1];
            cfg_req_id = 7'd33; cfg_sync_id = 5'd31; cfg_count = 5'd3;
            cfg_sync_pol = 2'(pol);
            idle_channel();
            sync_in[31] = 1'(s0); tick(); tick();
            cfg_sync_en = 1; req_in[33] = 1'b1; tick(); tick();
            chk("R3 no edge no connect", req_out, 1'b0);
            sync_in[31] = ~1'(s0); tick();
            chk("R3 polarity decides connect", req_out, exp_open);
            idle_channel();
            sync_in[31] = 1'b0; tick(); tick();
         end
      end

      // R6/R7: direct-mode events, count 0 then 2
      cfg_req_id = 7'd9; cfg_sync_pol = 2'b00;
      for (int n = 0; n < 3; n += 2) begin
         cfg_count = 5'(n);
         idle_channel();
         cfg_event_en = 1; tick();
         req_in[10] = 1'b1; tick(); req_in[10] = 1'b0; tick();
         chk("R6 other line not counted", event_pulse, 1'b0);
         for (int k = 0; k < 6; k++) begin
            req_in[9] = 1'b1; tick();
            req_in[9] = 1'b0; tick();
            chk("R7 direct mode event", event_pulse, ((k % (n + 1)) == n));
         end
      end

      // R8/R9: overrun, sticky, clear, set beats clear
      cfg_req_id = 7'd40; cfg_sync_id = 5'd7; cfg_count = 5'd3; cfg_sync_pol = 2'b01;
      cfg_ovr_ie = 0;
      idle_channel();
      cfg_sync_en = 1; req_in[40] = 1'b1; tick();
      sync_pulse(7);
      chk("R5 window open", req_out, 1'b1);
      chk("R8 no overrun yet", ovr_flag, 1'b0);
      sync_in[7] = 1'b1; tick();
      chk("R8 overrun set", ovr_flag, 1'b1);
      chk("R9 irq masked", ovr_irq, 1'b0);
      cfg_ovr_ie = 1; #1;
      chk("R9 irq enabled", ovr_irq, 1'b1);
      sync_in[7] = 1'b0; tick(); tick();
      chk("R8 flag sticky", ovr_flag, 1'b1);
      ovr_clear = 1; tick(); ovr_clear = 0;
      chk("R8 flag cleared", ovr_flag, 1'b0);
      chk("R9 irq follows flag", ovr_irq, 1'b0);
      sync_in[7] = 1'b1; ovr_clear = 1; tick(); ovr_clear = 0;
      chk("R8 set wins over clear", ovr_flag, 1'b1);
      sync_in[7] = 1'b0;
      idle_channel();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule